// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Tracker (L1 side)

This block sits in a first-level cache controller, between the processor's request port and the path to the shared memory-side cache. It handles the two halves of an atomic read-modify-write. A load-linked request records the cache line it touched and raises a single reservation flag. A later store-conditional is checked locally against that record. When the flag is clear or the line differs, the block answers failure to the processor at once and sends nothing toward memory. When the check passes, the store-conditional goes to the memory side, and the Boolean verdict that comes back is handed to the processor.

Invalidation notices from the memory side that name the reserved line cancel the reservation. A lookup port tells the cache whether a line is currently covered by a live reservation, so the locally held copy of that line can be used by the atomic sequence. While a forwarded store-conditional is outstanding, the processor request port is stalled through its valid/ready handshake. The cache arrays, refill logic and interconnect protocol are outside this block.

Top module: `llsc_resv_tracker`

## Requirements
- R1: A load-linked request (`cpu_req_op` = 2'b01) accepted while `cpu_req_ready` is high stores the line part of `cpu_req_addr` (bits above the low `LINE_OFS` bits) as the reserved line.
- R2: An accepted load-linked request sets the reservation flag, so the reserved line reports `lookup_hit` from the next cycle.
- R3: `lookup_hit` is high exactly when the reservation flag is set and `lookup_line` equals the reserved line.
- R4: An accepted store-conditional (`cpu_req_op` = 2'b10) raises `mem_sc_valid` in the next cycle, carrying the full request address on `mem_sc_addr`, only when the flag is set and the address's line equals the reserved line.
- R5: For a forwarded store-conditional, `cpu_rsp_valid` pulses for one cycle in the cycle after `mem_rsp_valid` is seen, with `cpu_rsp_ok` equal to `mem_rsp_ok`; a memory response while no store-conditional is awaiting one is ignored.
- R6: A store-conditional that fails the local check pulses `cpu_rsp_valid` with `cpu_rsp_ok` low in the next cycle, and `mem_sc_valid` stays low.
- R7: The reservation flag is clear after every store-conditional completes, whether it succeeded or failed.
- R8: An invalidation (`inv_valid`) whose `inv_line` equals the reserved line clears the flag; one naming another line leaves it unchanged.
- R9: Only the line part of an address is compared; addresses differing only in the low `LINE_OFS` bits match.
- R10: `cpu_req_ready` is low from the cycle after a store-conditional is forwarded until the cycle after its memory response; `mem_sc_valid` and `mem_sc_addr` hold steady until `mem_sc_ready` is seen high.
- R11: An invalidation of the line named by a load-linked in the same cycle leaves the flag clear; an invalidation of the reserved line in the same cycle as a store-conditional makes that store-conditional fail locally.
- R12: Requests with any other `cpu_req_op` code (2'b00, 2'b11) are accepted and have no effect on the reservation or the responses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req_valid | input | 1 | Processor request valid |
| cpu_req_ready | output | 1 | Block can accept a processor request |
| cpu_req_op | input | 2 | 01 load-linked, 10 store-conditional, others no effect |
| cpu_req_addr | input | ADDR_W | Request byte address |
| cpu_rsp_valid | output | 1 | Store-conditional outcome valid (one-cycle pulse) |
| cpu_rsp_ok | output | 1 | Store-conditional succeeded |
| lookup_line | input | ADDR_W-LINE_OFS | Line probed for a live reservation |
| lookup_hit | output | 1 | Probed line is reserved |
| inv_valid | input | 1 | Invalidation notice valid |
| inv_line | input | ADDR_W-LINE_OFS | Line being invalidated |
| mem_sc_valid | output | 1 | Forwarded store-conditional valid |
| mem_sc_ready | input | 1 | Memory side accepts the store-conditional |
| mem_sc_addr | output | ADDR_W | Address of the forwarded store-conditional |
| mem_rsp_valid | input | 1 | Memory-side verdict valid |
| mem_rsp_ok | input | 1 | Memory-side verdict: success |

## Verification
The assertions take for granted that the memory side returns at most one verdict per forwarded store-conditional and that inputs are free of X after reset; they make no demand on when `mem_sc_ready` or `mem_rsp_valid` arrive. The stimulus keeps within this by driving every input to a known value from reset onward, while deliberately raising `mem_rsp_valid` at times when nothing is outstanding so that the ignore rule is exercised. Random phases vary the handshake delays, and line addresses are drawn from a small pool so that matches, mismatches and same-cycle collisions between requests and invalidations happen often.

// File: rtl/llsc_pkg.sv
package llsc_pkg;

  localparam logic [1:0] OP_LL = 2'b01;
  localparam logic [1:0] OP_SC = 2'b10;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_WAIT = 2'd2
  } sc_state_e;

endpackage

// File: rtl/llsc_resv_reg.sv
module llsc_resv_reg #(
  parameter int LINE_W = 26
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_i,
  input  logic [LINE_W-1:0] set_line_i,
  input  logic              clr_i,
  input  logic              inv_valid_i,
  input  logic [LINE_W-1:0] inv_line_i,
  input  logic [LINE_W-1:0] sc_line_i,
  input  logic [LINE_W-1:0] probe_line_i,
  output logic              flag_o,
  output logic [LINE_W-1:0] line_o,
  output logic              sc_match_o,
  output logic              probe_hit_o
);

  function automatic logic lines_equal(input logic [LINE_W-1:0] a,
                                       input logic [LINE_W-1:0] b);
    return (a ^ b) == '0;
  endfunction

  logic              flag_q;
  logic [LINE_W-1:0] line_q;
  logic              inv_hits_old;
  logic              inv_hits_new;

  assign inv_hits_old = inv_valid_i && lines_equal(inv_line_i, line_q);
  assign inv_hits_new = inv_valid_i && lines_equal(inv_line_i, set_line_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      line_q <= '0;
    end else if (set_i) begin
      line_q <= set_line_i;
      flag_q <= !inv_hits_new;
    end else if (clr_i || inv_hits_old) begin
      flag_q <= 1'b0;
    end
  end

  assign flag_o      = flag_q;
  assign line_o      = line_q;
  assign sc_match_o  = flag_q && lines_equal(sc_line_i, line_q) && !inv_hits_old;
  assign probe_hit_o = flag_q && lines_equal(probe_line_i, line_q);

  // R2: a load-linked without a colliding invalidation leaves a live reservation
  a_r2_ll_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i && !inv_hits_new) |=> (flag_o && line_o == $past(set_line_i)));

  // R8: invalidation of the reserved line drops it
  a_r8_inv_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_i && inv_hits_old) |=> !flag_o);

  // R11: load-linked racing an invalidation of its own line stays unreserved
  a_r11_ll_inv_race: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i && inv_hits_new) |=> !flag_o);

  // R7: completion of a store-conditional drops the reservation
  a_r7_clr_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !flag_o);

endmodule

// File: rtl/llsc_sc_fsm.sv
module llsc_sc_fsm
  import llsc_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sc_acc_i,
  input  logic              local_ok_i,
  input  logic [ADDR_W-1:0] sc_addr_i,
  input  logic              mem_sc_ready_i,
  input  logic              mem_rsp_valid_i,
  input  logic              mem_rsp_ok_i,
  output logic              idle_o,
  output logic              mem_sc_valid_o,
  output logic [ADDR_W-1:0] mem_sc_addr_o,
  output logic              rsp_valid_o,
  output logic              rsp_ok_o,
  output logic              sc_done_o
);

  sc_state_e         st_q;
  sc_state_e         st_d;
  logic [ADDR_W-1:0] addr_q;
  logic              rsp_v_q;
  logic              rsp_ok_q;
  logic              local_fail;
  logic              forward_now;
  logic              mem_done;

  assign local_fail  = (st_q == ST_IDLE) && sc_acc_i && !local_ok_i;
  assign forward_now = (st_q == ST_IDLE) && sc_acc_i && local_ok_i;
  assign mem_done    = (st_q == ST_WAIT) && mem_rsp_valid_i;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (forward_now)    st_d = ST_SEND;
      ST_SEND: if (mem_sc_ready_i) st_d = ST_WAIT;
      ST_WAIT: if (mem_done)       st_d = ST_IDLE;
      default:                     st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      addr_q   <= '0;
      rsp_v_q  <= 1'b0;
      rsp_ok_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      rsp_v_q <= local_fail || mem_done;
      if (forward_now) addr_q <= sc_addr_i;
      if (local_fail)    rsp_ok_q <= 1'b0;
      else if (mem_done) rsp_ok_q <= mem_rsp_ok_i;
    end
  end

  assign idle_o         = (st_q == ST_IDLE);
  assign mem_sc_valid_o = (st_q == ST_SEND);
  assign mem_sc_addr_o  = addr_q;
  assign rsp_valid_o    = rsp_v_q;
  assign rsp_ok_o       = rsp_ok_q;
  assign sc_done_o      = local_fail || mem_done;

  // R5: the memory verdict is passed through one cycle later
  a_r5_verdict_pass: assert property (@(posedge clk) disable iff (!rst_n)
    mem_done |=> (rsp_valid_o && rsp_ok_o == $past(mem_rsp_ok_i)));

  // R6: a local failure answers at once and sends nothing
  a_r6_local_fail: assert property (@(posedge clk) disable iff (!rst_n)
    local_fail |=> (rsp_valid_o && !rsp_ok_o && !mem_sc_valid_o));

  // R10: the forwarded request is held steady until taken
  a_r10_hold_req: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_sc_valid_o && !mem_sc_ready_i) |=> (mem_sc_valid_o && $stable(mem_sc_addr_o)));

  // R5: a response pulse never overlaps an outstanding request
  a_r5_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid_o |-> idle_o);

endmodule

// File: rtl/llsc_resv_tracker.sv
module llsc_resv_tracker
  import llsc_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int LINE_OFS = 6
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cpu_req_valid,
  output logic                       cpu_req_ready,
  input  logic [1:0]                 cpu_req_op,
  input  logic [ADDR_W-1:0]          cpu_req_addr,
  output logic                       cpu_rsp_valid,
  output logic                       cpu_rsp_ok,
  input  logic [ADDR_W-LINE_OFS-1:0] lookup_line,
  output logic                       lookup_hit,
  input  logic                       inv_valid,
  input  logic [ADDR_W-LINE_OFS-1:0] inv_line,
  output logic                       mem_sc_valid,
  input  logic                       mem_sc_ready,
  output logic [ADDR_W-1:0]          mem_sc_addr,
  input  logic                       mem_rsp_valid,
  input  logic                       mem_rsp_ok
);

  localparam int LINE_W = ADDR_W - LINE_OFS;

  logic              req_acc;
  logic              ll_acc;
  logic              sc_acc;
  logic [LINE_W-1:0] req_line;
  logic              resv_flag;
  logic [LINE_W-1:0] resv_line;
  logic              sc_local_ok;
  logic              sc_done;
  logic              fsm_idle;

  assign req_line      = cpu_req_addr[ADDR_W-1:LINE_OFS];
  assign cpu_req_ready = fsm_idle;
  assign req_acc       = cpu_req_valid && fsm_idle;
  assign ll_acc        = req_acc && (cpu_req_op == OP_LL);
  assign sc_acc        = req_acc && (cpu_req_op == OP_SC);

  llsc_resv_reg #(
    .LINE_W(LINE_W)
  ) u_resv (
    .clk          (clk),
    .rst_n        (rst_n),
    .set_i        (ll_acc),
    .set_line_i   (req_line),
    .clr_i        (sc_done),
    .inv_valid_i  (inv_valid),
    .inv_line_i   (inv_line),
    .sc_line_i    (req_line),
    .probe_line_i (lookup_line),
    .flag_o       (resv_flag),
    .line_o       (resv_line),
    .sc_match_o   (sc_local_ok),
    .probe_hit_o  (lookup_hit)
  );

  llsc_sc_fsm #(
    .ADDR_W(ADDR_W)
  ) u_fsm (
    .clk             (clk),
    .rst_n           (rst_n),
    .sc_acc_i        (sc_acc),
    .local_ok_i      (sc_local_ok),
    .sc_addr_i       (cpu_req_addr),
    .mem_sc_ready_i  (mem_sc_ready),
    .mem_rsp_valid_i (mem_rsp_valid),
    .mem_rsp_ok_i    (mem_rsp_ok),
    .idle_o          (fsm_idle),
    .mem_sc_valid_o  (mem_sc_valid),
    .mem_sc_addr_o   (mem_sc_addr),
    .rsp_valid_o     (cpu_rsp_valid),
    .rsp_ok_o        (cpu_rsp_ok),
    .sc_done_o       (sc_done)
  );

  // R4: a forward starts only from a live reservation on the same line
  a_r4_fwd_gate: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_sc_valid) |-> ($past(resv_flag) &&
                             $past(cpu_req_addr[ADDR_W-1:LINE_OFS]) == $past(resv_line)));

  // R7: when an outcome is reported the reservation is already gone
  a_r7_rsp_clears: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rsp_valid |-> !resv_flag);

  // R10: the processor port is stalled while a request is outstanding
  a_r10_stall: assert property (@(posedge clk) disable iff (!rst_n)
    mem_sc_valid |-> !cpu_req_ready);

endmodule

// File: tb/llsc_resv_tracker_tb.sv
`timescale 1ns/1ps
module llsc_resv_tracker_tb;

  localparam int AW = 32;
  localparam int LO = 6;
  localparam int LW = AW - LO;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cpu_req_valid = 1'b0;
  logic          cpu_req_ready;
  logic [1:0]    cpu_req_op = 2'b00;
  logic [AW-1:0] cpu_req_addr = '0;
  logic          cpu_rsp_valid;
  logic          cpu_rsp_ok;
  logic [LW-1:0] lookup_line = '0;
  logic          lookup_hit;
  logic          inv_valid = 1'b0;
  logic [LW-1:0] inv_line = '0;
  logic          mem_sc_valid;
  logic          mem_sc_ready = 1'b1;
  logic [AW-1:0] mem_sc_addr;
  logic          mem_rsp_valid = 1'b0;
  logic          mem_rsp_ok = 1'b0;

  always #2 clk = ~clk;

  llsc_resv_tracker #(.ADDR_W(AW), .LINE_OFS(LO)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
    .cpu_req_op(cpu_req_op), .cpu_req_addr(cpu_req_addr),
    .cpu_rsp_valid(cpu_rsp_valid), .cpu_rsp_ok(cpu_rsp_ok),
    .lookup_line(lookup_line), .lookup_hit(lookup_hit),
    .inv_valid(inv_valid), .inv_line(inv_line),
    .mem_sc_valid(mem_sc_valid), .mem_sc_ready(mem_sc_ready),
    .mem_sc_addr(mem_sc_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_ok(mem_rsp_ok)
  );

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  function automatic int unsigned line_of(input logic [AW-1:0] a);
    return int'(a / (1 << LO));
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at %0t: actual %0h expected %0h", req, $time, act, exp);
    end
  endtask

  // behavioural reference: 0 idle, 1 request out, 2 awaiting verdict
  int            m_st = 0;
  bit            m_flag = 0;
  int unsigned   m_line = 0;
  logic [AW-1:0] m_addr = '0;
  bit            e_rsp_v = 0;
  bit            e_rsp_ok = 0;
  bit            e_from_mem = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_flag = 0; m_line = 0; e_rsp_v = 0; e_rsp_ok = 0;
    end else begin
      bit inv_old;
      inv_old = inv_valid && (int'(inv_line) == m_line);
      e_rsp_v = 0;
      if (m_st == 0) begin
        if (cpu_req_valid && cpu_req_op == 2'b01) begin
          m_line = line_of(cpu_req_addr);
          m_flag = !(inv_valid && int'(inv_line) == m_line);
        end else if (cpu_req_valid && cpu_req_op == 2'b10) begin
          if (m_flag && line_of(cpu_req_addr) == m_line && !inv_old) begin
            m_st = 1; m_addr = cpu_req_addr;
            if (inv_old) m_flag = 0;
          end else begin
            e_rsp_v = 1; e_rsp_ok = 0; e_from_mem = 0; m_flag = 0;
          end
        end else if (inv_old) m_flag = 0;
      end else if (m_st == 1) begin
        if (inv_old) m_flag = 0;
        if (mem_sc_ready) m_st = 2;
      end else begin
        if (inv_old) m_flag = 0;
        if (mem_rsp_valid) begin
          e_rsp_v = 1; e_rsp_ok = mem_rsp_ok; e_from_mem = 1; m_flag = 0; m_st = 0;
        end
      end
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(cpu_req_ready == (m_st == 0), "R10 ready", cpu_req_ready, m_st == 0);
      chk(mem_sc_valid == (m_st == 1), "R4 mem_sc_valid", mem_sc_valid, m_st == 1);
      if (m_st == 1) chk(mem_sc_addr == m_addr, "R4 mem_sc_addr", mem_sc_addr, m_addr);
      chk(cpu_rsp_valid == e_rsp_v, e_from_mem ? "R5 rsp_valid" : "R6 rsp_valid",
          cpu_rsp_valid, e_rsp_v);
      if (e_rsp_v)
        chk(cpu_rsp_ok == e_rsp_ok, e_from_mem ? "R5 rsp_ok" : "R6 rsp_ok",
            cpu_rsp_ok, e_rsp_ok);
      chk(lookup_hit == (m_flag && int'(lookup_line) == m_line), "R3 lookup_hit",
          lookup_hit, m_flag && int'(lookup_line) == m_line);
    end
  end

  // memory-side responder
  int  rsp_delay = 1;
  bit  rsp_val = 1;
  bit  rnd_mode = 0;
  int  wcnt = 0;

  always @(negedge clk) begin
    #1;
    mem_sc_ready = rnd_mode ? 1'($urandom % 2) : 1'b1;
    if (m_st == 2) begin
      if (wcnt >= rsp_delay) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_ok = rnd_mode ? 1'($urandom % 2) : rsp_val;
        wcnt = 0;
      end else begin
        mem_rsp_valid = 1'b0;
        wcnt++;
      end
    end else begin
      mem_rsp_valid = rnd_mode ? 1'($urandom % 2) : 1'b0;
      mem_rsp_ok = 1'($urandom % 2);
      wcnt = 0;
    end
  end

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic wait_idle();
    while (!cpu_req_ready) step();
  endtask

  task automatic issue(input logic [1:0] op, input logic [AW-1:0] a);
    wait_idle();
    cpu_req_valid = 1'b1; cpu_req_op = op; cpu_req_addr = a;
    step();
    cpu_req_valid = 1'b0; cpu_req_op = 2'b00;
  endtask

  task automatic inval(input logic [AW-1:0] a);
    inv_valid = 1'b1; inv_line = LW'(a >> LO);
    step();
    inv_valid = 1'b0;
  endtask

  task automatic probe_expect(input logic [AW-1:0] a, input bit exp, input string req);
    lookup_line = LW'(a >> LO);
    @(negedge clk);
    chk(lookup_hit == exp, req, lookup_hit, exp);
    #1;
  endtask

  initial begin
    #(4ns * 150000);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    @(negedge clk);
    chk(cpu_req_ready && !cpu_rsp_valid && !mem_sc_valid && !lookup_hit,
        "R3 reset state", {cpu_req_ready, cpu_rsp_valid, mem_sc_valid, lookup_hit}, 4'b1000);
    #1;

    // R1 R2 R9: reservation recorded with line granularity
    issue(2'b01, 32'h0000_1004);
    probe_expect(32'h0000_1030, 1'b1, "R2 ll sets flag");
    probe_expect(32'h0000_1040, 1'b0, "R1 other line");
    // forwarded, success (R4 R5 R9)
    rsp_delay = 2; rsp_val = 1;
    issue(2'b10, 32'h0000_1008);
    wait_idle(); step();
    // R7: no reservation left, second SC fails locally
    probe_expect(32'h0000_1000, 1'b0, "R7 cleared after success");
    issue(2'b10, 32'h0000_1008);
    step();
    // R6: address mismatch
    issue(2'b01, 32'h0000_2000);
    issue(2'b10, 32'h0000_3000);
    step();
    probe_expect(32'h0000_2000, 1'b0, "R7 cleared after local fail");
    // R8: invalidation of reserved line
    issue(2'b01, 32'h0000_2000);
    inval(32'h0000_2010);
    probe_expect(32'h0000_2000, 1'b0, "R8 inv clears");
    issue(2'b10, 32'h0000_2000);
    step();
    // R8: other line no effect; forwarded verdict false (R5)
    issue(2'b01, 32'h0000_2000);
    inval(32'h0000_5000);
    probe_expect(32'h0000_2000, 1'b1, "R8 other inv ignored");
    rsp_val = 0; rsp_delay = 0;
    issue(2'b10, 32'h0000_203C);
    wait_idle(); step();
    // R12: other op codes
    issue(2'b01, 32'h0000_2000);
    issue(2'b00, 32'h0000_4000);
    issue(2'b11, 32'h0000_2000);
    probe_expect(32'h0000_2000, 1'b1, "R12 other ops ignored");
    // R11: SC racing invalidation of reserved line
    wait_idle();
    cpu_req_valid = 1; cpu_req_op = 2'b10; cpu_req_addr = 32'h0000_2000;
    inv_valid = 1; inv_line = LW'(32'h0000_2000 >> LO);
    step();
    cpu_req_valid = 0; inv_valid = 0;
    step();
    // R11: LL racing invalidation of its own line
    cpu_req_valid = 1; cpu_req_op = 2'b01; cpu_req_addr = 32'h0000_6000;
    inv_valid = 1; inv_line = LW'(32'h0000_6000 >> LO);
    step();
    cpu_req_valid = 0; inv_valid = 0;
    probe_expect(32'h0000_6000, 1'b0, "R11 ll inv race");
    // invalidation during wait; verdict still from memory (R5 R8)
    issue(2'b01, 32'h0000_7000);
    rsp_val = 1; rsp_delay = 3;
    issue(2'b10, 32'h0000_7000);
    inval(32'h0000_7000);
    wait_idle(); step();

    // random phase
    rnd_mode = 1;
    for (int i = 0; i < 3000; i++) begin
      logic [AW-1:0] a;
      a = AW'((($urandom % 4) << LO) | ($urandom % 64));
      cpu_req_valid = 1'($urandom % 2);
      cpu_req_op = 2'($urandom % 4);
      cpu_req_addr = a;
      inv_valid = ($urandom % 6) == 0;
      inv_line = LW'($urandom % 4);
      lookup_line = LW'($urandom % 4);
      step();
    end
    cpu_req_valid = 0; inv_valid = 0; rnd_mode = 0;
    repeat (20) step();

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule